// File: doc/BRIEF.md
# Timer Counter with Trigger-Driven Slave Control

This block is an up-counter with a programmable wrap value and a slave controller that lets one of eight trigger sources act on the count. The trigger sources arrive already conditioned, as single-cycle pulses in the core clock domain. They are four internal triggers from neighbouring timers, a pulse for either edge of channel 1, two filtered channel inputs and a filtered external trigger line. A 3-bit select picks one of them. A 3-bit slave mode field decides what the chosen trigger does: it can act as the counting clock, it can clear the counter, or it can be ignored.

A separate enable routes the external trigger line straight to the count clock, and that route overrides the selected trigger. The slave reset mode can be used at the same time, so one pulse source counts while another restarts the count. On a wrap or a trigger-driven clear the block raises a one-cycle update event. A master mode field picks the source of a one-cycle trigger-out pulse for timers downstream. An optional one-cycle delay on the trigger path keeps chained timers aligned with this timer's trigger-out.

Top module: `slvTimer`

## Requirements
- R1: While `rstN` is low, `count`, `updateEvt` and `trigOut` are all zero.
- R2: With `slaveMode` = 000 and `extClkEn` low, the counter adds one on every clock while `cntEnable` is high, and holds its value while `cntEnable` is low.
- R3: A count step taken while `count` equals `reloadVal` loads zero instead and raises `updateEvt` for that one cycle, together with the zero value.
- R4: `trigSel` picks the trigger source as follows: 000 to 011 select `itrPulse[0]` to `itrPulse[3]`, 100 selects `bothEdgePulse`, 101 selects `filtIn1Pulse`, 110 selects `filtIn2Pulse` and 111 selects `extTrigPulse`. Pulses on the sources that are not selected have no effect.
- R5: With `slaveMode` = 111 and `extClkEn` low, the counter steps once for each pulse of the selected trigger and holds in cycles that have no such pulse.
- R6: With `slaveMode` = 100, a selected trigger pulse while enabled clears the counter to zero and raises `updateEvt`. It wins over a step in the same cycle. Between triggers the counter keeps counting from its normal source.
- R7: With `extClkEn` high, only `extTrigPulse` steps the counter, whatever the slave mode and the selected trigger are. A slave reset from the selected trigger still applies.
- R8: With `msDelay` high, the selected trigger takes effect one clock later than it would with `msDelay` low.
- R9: In a cycle where `trigSel` differs from its value in the previous cycle, no trigger is taken. After reset, the previous value counts as 000.
- R10: `trigOut` is a one-cycle pulse, aligned with the cycle in which the count change appears. Its source depends on `masterMode`: 000 gives a slave-mode clear, 001 gives a rising edge of `cntEnable`, 010 gives an update event, and any other value keeps it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntEnable | input | 1 | Counter enable |
| reloadVal | input | 16 | Wrap value of the counter |
| trigSel | input | 3 | Trigger source select |
| slaveMode | input | 3 | Slave mode: 000 off, 100 reset, 111 trigger clock |
| extClkEn | input | 1 | External trigger line clocks the counter |
| msDelay | input | 1 | Delay the trigger path by one cycle |
| masterMode | input | 3 | Trigger-out source select |
| itrPulse | input | 4 | Internal trigger pulses |
| bothEdgePulse | input | 1 | Pulse per channel 1 edge, either direction |
| filtIn1Pulse | input | 1 | Filtered channel 1 pulse |
| filtIn2Pulse | input | 1 | Filtered channel 2 pulse |
| extTrigPulse | input | 1 | Filtered external trigger pulse |
| count | output | 16 | Counter value |
| updateEvt | output | 1 | Update event pulse |
| trigOut | output | 1 | Trigger-out pulse |

## Verification
The bench sweeps every trigger select code and fires pulses on all the other sources at once. A mux with a swapped index or a leaking source then shows up as a stray count. It lines up a slave clear with a wrap, and also with a step in the same cycle, so a design that gives the increment priority would show a count of one instead of zero. It drives the external-trigger enable together with a live selected trigger, which catches a design that adds both clocks or lets the wrong one win. It also sets the delay bit and changes the trigger select while a pulse is present. A design that skips the extra stage would count one cycle early, and one that ignores the select change would take a spurious trigger.

// File: rtl/slvTimerPkg.sv
package slvTimerPkg;

  localparam int unsigned ITR_COUNT = 4;
  localparam int unsigned SRC_COUNT = ITR_COUNT + 4;
  localparam int unsigned SEL_W     = $clog2(SRC_COUNT);

  localparam logic [2:0] SLV_OFF    = 3'b000;
  localparam logic [2:0] SLV_RESET  = 3'b100;
  localparam logic [2:0] SLV_EXTCLK = 3'b111;

  localparam logic [2:0] MST_RESET  = 3'b000;
  localparam logic [2:0] MST_ENABLE = 3'b001;
  localparam logic [2:0] MST_UPDATE = 3'b010;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic tick;    // advance the counter
    logic clr;     // slave reset of the counter
    logic enRise;  // counter enable just went high
  } strobe_t;

endpackage

// File: rtl/slvTimerCtrl.sv
module slvTimerCtrl
  import slvTimerPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cntEnable,
  input  logic                 extClkEn,
  input  logic                 msDelay,
  input  logic [SEL_W-1:0]     trigSel,
  input  logic [2:0]           slaveMode,
  input  logic [ITR_COUNT-1:0] itrPulse,
  input  logic                 bothEdgePulse,
  input  logic                 filtIn1Pulse,
  input  logic                 filtIn2Pulse,
  input  logic                 extTrigPulse,
  output strobe_t              strobes
);

  logic [SRC_COUNT-1:0] srcVec;
  logic [SEL_W-1:0]     selPrev;
  logic                 trigRaw;
  logic                 trigQ;
  logic                 trigEff;
  logic                 enPrev;
  logic                 selStable;

  // source order is fixed by the select encoding
  assign srcVec = {extTrigPulse, filtIn2Pulse, filtIn1Pulse, bothEdgePulse, itrPulse};

  // drop the trigger in any cycle where the select moves
  assign selStable = (trigSel == selPrev);
  assign trigRaw   = srcVec[trigSel] & selStable;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selPrev <= '0;
      trigQ   <= 1'b0;
      enPrev  <= 1'b0;
    end else begin
      selPrev <= trigSel;
      trigQ   <= trigRaw;
      enPrev  <= cntEnable;
    end
  end

  assign trigEff = msDelay ? trigQ : trigRaw;

  always_comb begin
    strobes        = '0;
    strobes.enRise = cntEnable & ~enPrev;
    strobes.clr    = cntEnable & (slaveMode == SLV_RESET) & trigEff;
    if (cntEnable) begin
      if (extClkEn)                     strobes.tick = extTrigPulse;
      else if (slaveMode == SLV_EXTCLK) strobes.tick = trigEff;
      else                              strobes.tick = 1'b1;
    end
  end

endmodule

// File: rtl/slvTimerData.sv
module slvTimerData
  import slvTimerPkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic [2:0]       masterMode,
  output logic [CNT_W-1:0] count,
  output logic             updateEvt,
  output logic             trigOut
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic wrapHit;
  logic updNext;
  logic outNext;

  assign wrapHit = strobes.tick & (count == reloadVal);
  assign updNext = strobes.clr | wrapHit;

  always_comb begin
    case (masterMode)
      MST_RESET:  outNext = strobes.clr;
      MST_ENABLE: outNext = strobes.enRise;
      MST_UPDATE: outNext = updNext;
      default:    outNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      updateEvt <= 1'b0;
      trigOut   <= 1'b0;
    end else begin
      if (strobes.clr)       count <= '0;
      else if (wrapHit)      count <= '0;
      else if (strobes.tick) count <= count + CNT_ONE;
      updateEvt <= updNext;
      trigOut   <= outNext;
    end
  end

endmodule

// File: rtl/slvTimer.sv
module slvTimer
  import slvTimerPkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cntEnable,
  input  logic [CNT_W-1:0]     reloadVal,
  input  logic [2:0]           trigSel,
  input  logic [2:0]           slaveMode,
  input  logic                 extClkEn,
  input  logic                 msDelay,
  input  logic [2:0]           masterMode,
  input  logic [3:0]           itrPulse,
  input  logic                 bothEdgePulse,
  input  logic                 filtIn1Pulse,
  input  logic                 filtIn2Pulse,
  input  logic                 extTrigPulse,
  output logic [CNT_W-1:0]     count,
  output logic                 updateEvt,
  output logic                 trigOut
);

  strobe_t strobes;

  slvTimerCtrl ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .cntEnable     (cntEnable),
    .extClkEn      (extClkEn),
    .msDelay       (msDelay),
    .trigSel       (trigSel),
    .slaveMode     (slaveMode),
    .itrPulse      (itrPulse),
    .bothEdgePulse (bothEdgePulse),
    .filtIn1Pulse  (filtIn1Pulse),
    .filtIn2Pulse  (filtIn2Pulse),
    .extTrigPulse  (extTrigPulse),
    .strobes       (strobes)
  );

  slvTimerData #(.CNT_W(CNT_W)) data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reloadVal  (reloadVal),
    .masterMode (masterMode),
    .count      (count),
    .updateEvt  (updateEvt),
    .trigOut    (trigOut)
  );

endmodule

// File: rtl/slvTimerChecker.sv
module slvTimerChecker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntEnable,
  input logic [CNT_W-1:0] reloadVal,
  input logic [2:0]       slaveMode,
  input logic             extClkEn,
  input logic             msDelay,
  input logic [2:0]       masterMode,
  input logic [3:0]       itrPulse,
  input logic             bothEdgePulse,
  input logic             filtIn1Pulse,
  input logic             filtIn2Pulse,
  input logic             extTrigPulse,
  input logic [CNT_W-1:0] count,
  input logic             updateEvt,
  input logic             trigOut
);

  logic anySrc;
  assign anySrc = (|itrPulse) | bothEdgePulse | filtIn1Pulse | filtIn2Pulse | extTrigPulse;

  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (count == '0) && !updateEvt && !trigOut);

  p_hold_disabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cntEnable |=> $stable(count));

  p_single_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (count != '0) |-> (count == $past(count) + 1'b1) || (count == $past(count)));

  p_update_at_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    updateEvt |-> (count == '0));

  p_idle_trigger_clock_r5: assert property (@(posedge clk) disable iff (!rstN)
    (slaveMode == 3'b111 && !extClkEn && !msDelay && !anySrc) |=> $stable(count));

  p_ext_clock_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    (extClkEn && !extTrigPulse && slaveMode != 3'b100) |=> $stable(count));

  p_trigout_update_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(masterMode) == 3'b010) |-> (trigOut == updateEvt));

endmodule

bind slvTimer slvTimerChecker #(.CNT_W(CNT_W)) chk (
  .clk           (clk),
  .rstN          (rstN),
  .cntEnable     (cntEnable),
  .reloadVal     (reloadVal),
  .slaveMode     (slaveMode),
  .extClkEn      (extClkEn),
  .msDelay       (msDelay),
  .masterMode    (masterMode),
  .itrPulse      (itrPulse),
  .bothEdgePulse (bothEdgePulse),
  .filtIn1Pulse  (filtIn1Pulse),
  .filtIn2Pulse  (filtIn2Pulse),
  .extTrigPulse  (extTrigPulse),
  .count         (count),
  .updateEvt     (updateEvt),
  .trigOut       (trigOut)
);

// File: tb/slvTimer_test.sv
module slvTimer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntEnable = 1'b0;
  logic [15:0] reloadVal = '0;
  logic [2:0]  trigSel = '0;
  logic [2:0]  slaveMode = '0;
  logic        extClkEn = 1'b0;
  logic        msDelay = 1'b0;
  logic [2:0]  masterMode = '0;
  logic [7:0]  pulses = '0;   // bit index equals the trigger select code
  logic [15:0] count;
  logic        updateEvt;
  logic        trigOut;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [15:0] cnt;
    logic        upd;
    logic        tro;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  // requirement-level model state
  logic [15:0] mCount = '0;
  logic [2:0]  mSelPrev = '0;
  logic        mTrigQ = 1'b0;
  logic        mEnPrev = 1'b0;

  always #2 clk = ~clk;

  slvTimer uut (
    .clk           (clk),
    .rstN          (rstN),
    .cntEnable     (cntEnable),
    .reloadVal     (reloadVal),
    .trigSel       (trigSel),
    .slaveMode     (slaveMode),
    .extClkEn      (extClkEn),
    .msDelay       (msDelay),
    .masterMode    (masterMode),
    .itrPulse      (pulses[3:0]),
    .bothEdgePulse (pulses[4]),
    .filtIn1Pulse  (pulses[5]),
    .filtIn2Pulse  (pulses[6]),
    .extTrigPulse  (pulses[7]),
    .count         (count),
    .updateEvt     (updateEvt),
    .trigOut       (trigOut)
  );

  task automatic check(input string tag, input logic [15:0] c, input logic u, input logic t,
                       input logic [15:0] ec, input logic eu, input logic et);
    checks++;
    if (c !== ec || u !== eu || t !== et) begin
      failures++;
      $display("FAIL %s count=%0d exp %0d upd=%b exp %b trigOut=%b exp %b",
               tag, c, ec, u, eu, t, et);
    end
  endtask

  // driver: apply one cycle of pulses, predict the result, queue it
  task automatic step(input logic [7:0] p, input string tag);
    logic raw, eff, clr, tick, wrap, upd, tro;
    logic [15:0] nxt;
    exp_t e;
    pulses = p;
    raw  = p[trigSel] && (trigSel == mSelPrev);       // R4, R9
    eff  = msDelay ? mTrigQ : raw;                     // R8
    clr  = cntEnable && slaveMode == 3'b100 && eff;   // R6
    if (!cntEnable)                tick = 1'b0;
    else if (extClkEn)             tick = p[7];       // R7
    else if (slaveMode == 3'b111)  tick = eff;        // R5
    else                           tick = 1'b1;       // R2
    wrap = tick && (mCount == reloadVal);              // R3
    upd  = clr || wrap;
    nxt  = clr ? 16'd0 : (tick ? (wrap ? 16'd0 : mCount + 16'd1) : mCount);
    case (masterMode)                                  // R10
      3'b000:  tro = clr;
      3'b001:  tro = cntEnable && !mEnPrev;
      3'b010:  tro = upd;
      default: tro = 1'b0;
    endcase
    mCount = nxt; mSelPrev = trigSel; mTrigQ = raw; mEnPrev = cntEnable;
    e.cnt = nxt; e.upd = upd; e.tro = tro; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
  endtask

  // monitor: compare queued predictions after each edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(e.tag, count, updateEvt, trigOut, e.cnt, e.upd, e.tro);
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", count, updateEvt, trigOut, 16'd0, 1'b0, 1'b0);
    rstN = 1'b1;

    // R2 / R3: free run with wrap at 5, trigger-out from update
    reloadVal = 16'd5; masterMode = 3'b010; cntEnable = 1'b1;
    repeat (8) step(8'h00, "R3");
    cntEnable = 1'b0;
    repeat (3) step(8'hFF, "R2");
    cntEnable = 1'b1;
    repeat (2) step(8'h00, "R2");
    reloadVal = 16'd0;
    repeat (3) step(8'h00, "R3");

    // R5: trigger clock from filtered input 1
    reloadVal = 16'd100; slaveMode = 3'b111; trigSel = 3'd5;
    step(8'h20, "R9");
    step(8'h20, "R5");
    step(8'h00, "R5");
    step(8'hDF, "R5");
    step(8'h20, "R5");

    // R4: every select code, other sources fire first
    for (int s = 0; s < 8; s++) begin
      trigSel = 3'(s);
      step(8'(1 << s), "R9");
      step(~8'(1 << s), "R4");
      step(8'(1 << s), "R4");
    end

    // R8: delayed trigger path
    msDelay = 1'b1;
    step(8'h80, "R8");
    step(8'h00, "R8");
    step(8'h00, "R8");
    msDelay = 1'b0;

    // R6: slave reset on filtered input 2
    slaveMode = 3'b100; trigSel = 3'd6; masterMode = 3'b000;
    step(8'h40, "R9");
    repeat (3) step(8'h00, "R6");
    step(8'h40, "R6");
    step(8'h00, "R6");
    reloadVal = 16'd3; trigSel = 3'd4;
    step(8'h00, "R9");
    repeat (3) step(8'h00, "R6");
    step(8'h10, "R6");
    step(8'h10, "R6");

    // R7: external line clocks, selected trigger ignored as clock
    reloadVal = 16'd100; extClkEn = 1'b1; slaveMode = 3'b111; trigSel = 3'd5; masterMode = 3'b010;
    step(8'h00, "R7");
    step(8'h20, "R7");
    step(8'h80, "R7");
    step(8'hA0, "R7");
    step(8'h80, "R7");
    slaveMode = 3'b100;
    step(8'h80, "R7");
    step(8'hA0, "R7");
    step(8'h80, "R7");
    extClkEn = 1'b0; slaveMode = 3'b000;

    // R10: trigger-out on enable rise, then an unused code
    masterMode = 3'b001; cntEnable = 1'b0;
    step(8'h00, "R10");
    cntEnable = 1'b1;
    step(8'h00, "R10");
    step(8'h00, "R10");
    masterMode = 3'b011; reloadVal = 16'd2;
    repeat (6) step(8'h00, "R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule